// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is a watchdog for a small processor. A counting tick comes either from a free-running low-speed oscillator enable or from the instruction clock enable. The tick first passes through a fixed 256-step divider. The divider's carry then feeds a prescaler whose ratio, 1:2^N, is set by a 3-bit field in an 8-bit configuration register. The other five bits of that register are spare flags for software. When the prescaler overflows, the block records a time-out. What it requests depends on the state of the core at that moment: while the core runs, it asks for a full chip reset; while the core is halted, it asks only for a warm restart of the program counter and stack pointer.

Software keeps the watchdog quiet with clear strobes. A configuration pin selects one of two clearing modes. In single mode, one kind of clear strobe restarts the count. In paired mode, two distinct strobes must both be seen, in either order, before the count restarts. Entering halt also restarts the count. When the instruction clock is the source, the count freezes while halted, because that tick no longer arrives.

Top module: `wdog_core`

## Requirements
- R1: After the asynchronous active-low reset, `cold_rst_req`, `warm_rst_req` and `to_flag` are 0 and `cfg_rdata` reads 8'h07.
- R2: Bits 2..0 of the configuration register hold the ratio code N. After a clear, the first time-out comes 256*2^N ticks of the selected source later, so code 0 gives 256 ticks and code 7 gives 32768 ticks. The count then restarts and repeats with the same period.
- R3: Bits 7..3 of the configuration register read back exactly as written and have no effect on the time-out period.
- R4: With `pair_mode`=0, a clock cycle with `clr_one`=1 restarts the count. `clr_first` and `clr_second` are ignored.
- R5: With `pair_mode`=1, the count restarts only in the cycle in which both `clr_first` and `clr_second` have been seen. They may come in either order or together. A strobe seen earlier is kept across time-outs, and the record is emptied when the count restarts. `clr_one` is ignored in this mode.
- R6: A rising edge of `halt` restarts the count.
- R7: A time-out while `halt`=0 gives `cold_rst_req`. A time-out while `halt`=1 gives `warm_rst_req`. The two are never high together.
- R8: Each reset request is a pulse exactly one cycle wide.
- R9: `src_sel`=1 selects `osc_tick`, and `src_sel`=0 selects `instr_tick`. While the instruction clock is selected and `halt`=1, the count does not advance and no time-out occurs.
- R10: `to_flag` is set together with a reset request. It is cleared by a count restart caused by a clear strobe or by a rising edge of `halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | External reset, asynchronous, active low |
| src_sel | input | 1 | Tick source: 1 = oscillator enable, 0 = instruction clock enable |
| osc_tick | input | 1 | Low-speed oscillator tick enable |
| instr_tick | input | 1 | Instruction clock tick enable |
| halt | input | 1 | Core is halted |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data: [7:3] flags, [2:0] ratio code |
| cfg_rdata | output | 8 | Configuration register contents |
| pair_mode | input | 1 | 0 = single clear strobe, 1 = paired clear strobes |
| clr_one | input | 1 | Single-mode clear strobe |
| clr_first | input | 1 | First strobe of the pair |
| clr_second | input | 1 | Second strobe of the pair |
| cold_rst_req | output | 1 | Full chip reset request pulse |
| warm_rst_req | output | 1 | Warm restart request pulse |
| to_flag | output | 1 | Time-out has occurred |

## Verification
The hardest case to reach is a paired-mode strobe that is kept pending while a time-out happens. The test needs a clear, then one half of the pair, then a full period with no completion. After that it gives the other half and checks that this alone restarts the count. The bench sequences those strobes by cycle stamp and predicts every time-out edge from the last real restart. It does the same for halt entry and for resuming after a frozen halt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DIV_STAGES = 8;
  localparam int unsigned RATIO_W    = 3;
  localparam int unsigned CFG_W      = 8;
  localparam int unsigned PRE_STAGES = (1 << RATIO_W) - 1;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_COLD = 2'b01,
    REQ_WARM = 2'b10
  } req_kind_e;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned RATIO_W = 3,
  parameter logic [CFG_W-1:0] RST_VAL = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CFG_W-1:0]   wdata,
  output logic [CFG_W-1:0]   rdata,
  output logic [RATIO_W-1:0] ratio
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= RST_VAL;
    else if (we) cfg_q <= wdata;
  end

  assign rdata = cfg_q;
  assign ratio = cfg_q[RATIO_W-1:0];
endmodule

// File: rtl/wdog_clear_ctrl.sv
module wdog_clear_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pair_mode,
  input  logic clr_one,
  input  logic clr_first,
  input  logic clr_second,
  output logic clr_go
);
  logic seen_first_q, seen_second_q;
  logic have_first, have_second, pair_done;

  assign have_first  = seen_first_q  | clr_first;
  assign have_second = seen_second_q | clr_second;
  assign pair_done   = pair_mode & have_first & have_second;
  assign clr_go      = pair_mode ? pair_done : clr_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_first_q  <= 1'b0;
      seen_second_q <= 1'b0;
    end else if (!pair_mode || pair_done) begin
      seen_first_q  <= 1'b0;
      seen_second_q <= 1'b0;
    end else begin
      seen_first_q  <= have_first;
      seen_second_q <= have_second;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned DIV_STAGES = 8,
  parameter int unsigned RATIO_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               clr,
  input  logic [RATIO_W-1:0] ratio,
  output logic               timeout
);
  localparam int unsigned PRE_STAGES = (1 << RATIO_W) - 1;

  logic [DIV_STAGES-1:0] div_q;
  logic [PRE_STAGES-1:0] pre_q;
  logic [PRE_STAGES-1:0] pre_mask;
  logic div_carry, pre_full;

  // The mask covers the prescaler bits that must all be one at overflow.
  for (genvar g = 0; g < PRE_STAGES; g++) begin : g_mask
    assign pre_mask[g] = (ratio > RATIO_W'(g));
  end

  assign div_carry = tick & (&div_q);
  assign pre_full  = ((pre_q & pre_mask) == pre_mask);
  assign timeout   = div_carry & pre_full & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (clr) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (tick) begin
      div_q <= div_q + 1'b1;
      if (div_carry) pre_q <= pre_full ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             osc_tick,
  input  logic             instr_tick,
  input  logic             halt,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             pair_mode,
  input  logic             clr_one,
  input  logic             clr_first,
  input  logic             clr_second,
  output logic             cold_rst_req,
  output logic             warm_rst_req,
  output logic             to_flag
);
  logic [RATIO_W-1:0] ratio;
  logic halt_q, halt_rise, sw_clr, cnt_clr, tick, timeout;
  req_kind_e req_q;

  wdog_cfg_reg #(.CFG_W(CFG_W), .RATIO_W(RATIO_W), .RST_VAL(8'h07)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .ratio(ratio)
  );

  wdog_clear_ctrl u_clr (
    .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode), .clr_one(clr_one),
    .clr_first(clr_first), .clr_second(clr_second), .clr_go(sw_clr)
  );

  // The instruction clock stops in halt, so its tick is gated there.
  assign tick      = src_sel ? osc_tick : (instr_tick & ~halt);
  assign halt_rise = halt & ~halt_q;
  assign cnt_clr   = sw_clr | halt_rise;

  wdog_counter #(.DIV_STAGES(DIV_STAGES), .RATIO_W(RATIO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cnt_clr),
    .ratio(ratio), .timeout(timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      req_q   <= REQ_NONE;
      to_flag <= 1'b0;
    end else begin
      halt_q <= halt;
      if (timeout) req_q <= halt ? REQ_WARM : REQ_COLD;
      else         req_q <= REQ_NONE;
      if (timeout)      to_flag <= 1'b1;
      else if (cnt_clr) to_flag <= 1'b0;
    end
  end

  assign cold_rst_req = (req_q == REQ_COLD);
  assign warm_rst_req = (req_q == REQ_WARM);
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
  input logic clk,
  input logic rst_n,
  input logic src_sel,
  input logic halt,
  input logic cold_rst_req,
  input logic warm_rst_req,
  input logic to_flag
);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cold_rst_req && warm_rst_req));

  a_r7_warm_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |-> $past(halt));

  a_r7_cold_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    cold_rst_req |-> !$past(halt));

  a_r8_cold_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cold_rst_req |=> !cold_rst_req);

  a_r8_warm_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |=> !warm_rst_req);

  a_r9_frozen_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halt) && !$past(src_sel)) |-> !(cold_rst_req || warm_rst_req));

  a_r10_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_rst_req || warm_rst_req) |-> to_flag);
endmodule

bind wdog_core wdog_checker u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .halt(halt),
  .cold_rst_req(cold_rst_req), .warm_rst_req(warm_rst_req), .to_flag(to_flag)
);

// File: tb/test_wdog_core.sv
module test_wdog_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 1'b0, osc_tick = 1'b1, instr_tick = 1'b1, halt = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic pair_mode = 1'b0, clr_one = 1'b0, clr_first = 1'b0, clr_second = 1'b0;
  logic cold_rst_req, warm_rst_req, to_flag;

  int cyc = 0, total = 0, bad = 0;
  int pulses = 0, last_at = -1, wide = 0;
  bit last_warm = 1'b0, prev_req = 1'b0;

  always #10 clk = ~clk;

  wdog_core i_wdog_core (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .osc_tick(osc_tick),
    .instr_tick(instr_tick), .halt(halt), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pair_mode(pair_mode), .clr_one(clr_one),
    .clr_first(clr_first), .clr_second(clr_second),
    .cold_rst_req(cold_rst_req), .warm_rst_req(warm_rst_req), .to_flag(to_flag)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Pulse monitor, sampled between the rising and the falling edge.
  always @(posedge clk) begin
    #5;
    if (cold_rst_req || warm_rst_req) begin
      pulses++;
      last_at = cyc;
      last_warm = warm_rst_req;
      if (prev_req) wide++;
    end
    prev_req = cold_rst_req || warm_rst_req;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input logic one, input logic first, input logic second,
                           output int mark);
    clr_one = one; clr_first = first; clr_second = second;
    @(negedge clk);
    clr_one = 1'b0; clr_first = 1'b0; clr_second = 1'b0;
    mark = cyc;
  endtask

  task automatic wait_pulse(input int window, output int at, output bit was_warm);
    int p0 = pulses;
    int n = 0;
    at = -1; was_warm = 1'b0;
    while (n < window && pulses == p0) begin
      @(negedge clk);
      n++;
    end
    if (pulses != p0) begin at = last_at; was_warm = last_warm; end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0] ratio;
    logic       src;
    logic       hlt;
    logic       osc_on;
    logic       ins_on;
    logic [15:0] period;   // 0 means no time-out expected
    logic       warm;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd256,   1'b0},
    '{3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 16'd512,   1'b0},
    '{3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 16'd2048,  1'b0},
    '{3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 16'd32768, 1'b0},
    '{3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 16'd256,   1'b1},
    '{3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 16'd0,     1'b0},
    '{3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 16'd0,     1'b0}
  };

  initial begin
    int mark, at, mark2;
    bit w;

    // R1: reset state
    step(3);
    check(cold_rst_req == 1'b0 && warm_rst_req == 1'b0, "R1", "requests in reset",
          int'(cold_rst_req) + int'(warm_rst_req), 0);
    check(to_flag == 1'b0, "R1", "to_flag in reset", int'(to_flag), 0);
    check(cfg_rdata == 8'h07, "R1", "cfg reset value", int'(cfg_rdata), 7);
    rst_n = 1'b1;
    step(2);

    // Vector table: R2 R3 R7 R9 for period, source select and halt
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] wv;
      wv = {5'(i * 7 + 3), VECS[i].ratio};
      src_sel = VECS[i].src; osc_tick = VECS[i].osc_on; instr_tick = VECS[i].ins_on;
      halt = VECS[i].hlt;
      write_cfg(wv);
      check(cfg_rdata == wv, "R3", "cfg readback", int'(cfg_rdata), int'(wv));
      step(2);
      pulse_clr(1'b1, 1'b0, 1'b0, mark);
      if (VECS[i].period != 0) begin
        wait_pulse(int'(VECS[i].period) + 8, at, w);
        check(at == mark + int'(VECS[i].period), "R2", "time-out cycle",
              at - mark, int'(VECS[i].period));
        check(w == VECS[i].warm, "R7", "request kind warm", int'(w), int'(VECS[i].warm));
        check(to_flag == 1'b1, "R10", "to_flag after time-out", int'(to_flag), 1);
      end else begin
        wait_pulse(3000, at, w);
        check(at == -1, "R9", "no time-out without selected tick", at, -1);
      end
      halt = 1'b0;
      step(1);
    end
    check(wide == 0, "R8", "wide request pulses", wide, 0);

    // R4: single mode ignores the paired strobes
    src_sel = 1'b0; instr_tick = 1'b1; osc_tick = 1'b1; pair_mode = 1'b0;
    write_cfg(8'h00);
    pulse_clr(1'b1, 1'b0, 1'b0, mark);
    step(50);
    pulse_clr(1'b0, 1'b1, 1'b1, mark2);
    wait_pulse(300, at, w);
    check(at == mark + 256, "R4", "paired strobes ignored in single mode", at - mark, 256);
    check(w == 1'b0, "R7", "cold while running", int'(w), 0);

    // R10: clear strobe and halt entry clear to_flag
    check(to_flag == 1'b1, "R10", "to_flag set", int'(to_flag), 1);
    pulse_clr(1'b1, 1'b0, 1'b0, mark);
    check(to_flag == 1'b0, "R10", "to_flag after clear", int'(to_flag), 0);
    wait_pulse(300, at, w);
    check(to_flag == 1'b1, "R10", "to_flag set again", int'(to_flag), 1);
    halt = 1'b1;
    step(1);
    check(to_flag == 1'b0, "R10", "to_flag after halt entry", int'(to_flag), 0);

    // R9: instruction source frozen during halt, resumes afterwards
    step(1000);
    check(to_flag == 1'b0, "R9", "no time-out while halted", int'(to_flag), 0);
    halt = 1'b0;
    mark = cyc;
    wait_pulse(300, at, w);
    check(at == mark + 256, "R9", "resume after halt", at - mark, 256);

    // R6/R7: halt entry restarts the count; warm request while halted
    src_sel = 1'b1;
    pulse_clr(1'b1, 1'b0, 1'b0, mark);
    step(150);
    halt = 1'b1;
    step(1);
    mark2 = cyc;
    wait_pulse(300, at, w);
    check(at == mark2 + 256, "R6", "halt entry restarts count", at - mark2, 256);
    check(w == 1'b1, "R7", "warm while halted", int'(w), 1);
    halt = 1'b0;
    step(1);

    // R5: paired mode, either order, record kept across time-out
    src_sel = 1'b0; pair_mode = 1'b1;
    write_cfg(8'h01);
    pulse_clr(1'b0, 1'b1, 1'b1, mark);
    step(200);
    pulse_clr(1'b0, 1'b0, 1'b1, mark);
    step(100);
    pulse_clr(1'b0, 1'b1, 1'b0, mark);
    wait_pulse(600, at, w);
    check(at == mark + 512, "R5", "second then first clears", at - mark, 512);
    step(100);
    pulse_clr(1'b1, 1'b0, 1'b0, mark2);
    pulse_clr(1'b0, 1'b1, 1'b0, mark2);
    wait_pulse(600, at, w);
    check(at == mark + 1024, "R5", "half pair and single strobe do not clear",
          at - mark, 1024);
    pulse_clr(1'b0, 1'b0, 1'b1, mark);
    wait_pulse(600, at, w);
    check(at == mark + 512, "R5", "kept record completes pair", at - mark, 512);
    check(wide == 0, "R8", "wide request pulses", wide, 0);

    // R1: reset in mid-count
    step(100);
    rst_n = 1'b0;
    step(2);
    check(cfg_rdata == 8'h07 && to_flag == 1'b0, "R1", "state after reset",
          int'(cfg_rdata), 7);
    rst_n = 1'b1;
    step(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule